// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block is one channel of a descriptor-driven copy engine. Software places a chain of eight-word nodes in memory. Each node is an image of the channel's working registers. Software then writes the first node's address into the channel's link register and sets the list-start bit of the control word. From that point the walker runs the chain on its own:

- It reads each node over a single-word memory read port.
- It moves the node into the working registers.
- It runs the described copy. A byte down-counter stands in for the copy, advanced by a beat strobe from the datapath.
- It then follows the node's link word to the next node.

A zero link ends the walk. A link that points back into the chain makes the walk repeat without end, which serves a circular buffer. A cancel request stops the walk at any point.

The channel occupies a 64-byte register window. The window is picked out by the upper register-address bits, which must equal the `CHAN_ID` parameter. The working registers sit at window offsets 0x00 to 0x1C, in node-word order. The live remaining-byte count is at offset 0x30. The walker raises an event pulse when the first node of a chain has been loaded, and one more each time a node's copy finishes.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset the channel is idle (`busy` low, `mem_req` low, `evt` low), the count at offset 0x30 reads 0x00FFFFFF and the control word at offset 0x1C reads zero.
- R2: A write to the control word (offset 0x1C) with bit 4 set and bit 20 clear, while idle, starts a fetch at the address held in the link register (offset 0x14), with the two low address bits forced to zero. A fetch makes eight sequential single-word reads at ascending word addresses. The walker keeps `mem_req` and `mem_addr` steady until `mem_rvalid` is seen.
- R3: The eight fetched words are copied into the working registers at offsets 0x00, 0x04, ... 0x1C in fetch order. This happens only after the eighth word has arrived.
- R4: Offset 0x30 returns the size field (bits 23:0 of node word 4, the byte count minus one) once the node is loaded. It drops by one on each cycle with `beat_ok` high during the copy. It reads 0x00FFFFFF once no byte of the node is outstanding. Bits 31:24 read zero.
- R5: `evt` pulses for one cycle when the first node of a chain is loaded, and once for each finished node copy. A chain of N nodes therefore gives N+1 pulses.
- R6: After the copy of a node whose link word (word 5) is zero, the walker goes idle and clears bit 4 of the control word.
- R7: After the copy of a node with a non-zero link, the walker fetches the node at that link. A chain whose last link points to its first node keeps running until it is cancelled.
- R8: A control-word write with bit 20 set during a copy stops the walker at that clock edge. The count then reads all ones, and no completion event follows.
- R9: A cancel during a fetch drops the partly read node, and the working registers keep their previous values. The walker goes idle at the same edge that accepts the outstanding read.
- R10: Register accesses take effect only when `reg_addr[11:6]` equals `CHAN_ID`. A write to another window changes nothing, and a read of another window returns zero.
- R11: While `busy` is high, register writes do not change any working register. Only the cancel bit of a control-word write acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address (window select in bits 11:6) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Node-word read request |
| mem_addr | output | 32 | Node-word byte address, word aligned |
| mem_rvalid | input | 1 | Read data valid; completes the current request |
| mem_rdata | input | 32 | Read data |
| beat_ok | input | 1 | Datapath moved one byte this cycle |
| busy | output | 1 | Walker is fetching or copying |
| evt | output | 1 | One-cycle event pulse |

## Verification
The walker is driven with five patterns:

- A single node held with `beat_ok` low. This shows the count is loaded from the size field and moves one byte per beat.
- A three-node chain with a slow memory and alternating beats. This separates correct link following and event counting from timing that only works on a fast memory.
- A self-looping pair. This shows the walk does not stop on its own.
- A misaligned link. This shows the two low address bits are dropped.
- Cancels placed in the copy phase and in the middle of a stalled fetch. These tell an immediate stop apart from a stop that waits for the outstanding read, and show whether a partly read node ever reaches the working registers.

Writes to a neighbouring window and writes made while busy confirm that nothing outside the idle, own-window path alters state.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
   localparam int NODE_WORDS      = 8;
   localparam int W_SIZE          = 4;
   localparam int W_LINK          = 5;
   localparam int W_CTRL          = 7;
   localparam int CTRL_LIST_BIT   = 4;
   localparam int CTRL_CANCEL_BIT = 20;
   localparam int WIN_LSB         = 6;
   localparam logic [5:0] OFF_REMAIN = 6'h30;

   typedef enum logic [1:0] {
      WALK_IDLE  = 2'd0,
      WALK_FETCH = 2'd1,
      WALK_COPY  = 2'd2
   } walk_state_e;
endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch #(
   parameter int DATA_W     = 32,
   parameter int MEM_AW     = 32,
   parameter int NODE_WORDS = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [MEM_AW-1:0]                   start_addr,
   input  logic                                cancel,
   input  logic                                mem_rvalid,
   input  logic [DATA_W-1:0]                   mem_rdata,
   output logic                                mem_req,
   output logic [MEM_AW-1:0]                   mem_addr,
   output logic [NODE_WORDS-1:0][DATA_W-1:0]   node_q,
   output logic                                node_ready,
   output logic                                abort_done
);
   localparam int IDX_W = (NODE_WORDS > 1) ? $clog2(NODE_WORDS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

   logic              active;
   logic              drop;
   logic [IDX_W-1:0]  idx;
   logic [MEM_AW-1:0] base;
   logic [DATA_W-1:0] stage [NODE_WORDS];

   assign mem_req    = active;
   assign mem_addr   = base + (MEM_AW'(idx) << 2);
   assign abort_done = active & mem_rvalid & (drop | cancel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         drop       <= 1'b0;
         idx        <= '0;
         base       <= '0;
         node_ready <= 1'b0;
      end else begin
         node_ready <= 1'b0;
         if (start) begin
            active <= 1'b1;
            drop   <= 1'b0;
            idx    <= '0;
            base   <= start_addr & ~MEM_AW'(3);
         end else if (active) begin
            if (cancel) drop <= 1'b1;
            if (mem_rvalid) begin
               if (drop || cancel) begin
                  active <= 1'b0;
                  drop   <= 1'b0;
               end else if (idx == LAST_IDX) begin
                  active     <= 1'b0;
                  node_ready <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   for (genvar k = 0; k < NODE_WORDS; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[k] <= '0;
         else if (active && mem_rvalid && idx == IDX_W'(k))
            stage[k] <= mem_rdata;
      end
      assign node_q[k] = stage[k];
   end
endmodule

// File: rtl/dcw_bytecount.sv
module dcw_bytecount #(
   parameter int SIZE_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SIZE_W-1:0] load_val,
   input  logic              beat,
   input  logic              clear,
   output logic [SIZE_W-1:0] remain,
   output logic              counting,
   output logic              done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain   <= '1;
         counting <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            remain   <= '1;
            counting <= 1'b0;
         end else if (load) begin
            remain   <= load_val;
            counting <= 1'b1;
         end else if (counting && beat) begin
            if (remain == '0) begin
               remain   <= '1;
               counting <= 1'b0;
               done     <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dcw_regs.sv
module dcw_regs
   import dcw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               commit,
   input  logic [NODE_WORDS-1:0][DATA_W-1:0]  node_d,
   input  logic                               sw_we,
   input  logic [2:0]                         sw_idx,
   input  logic [DATA_W-1:0]                  sw_wdata,
   input  logic                               list_clr,
   output logic [NODE_WORDS-1:0][DATA_W-1:0]  words
);
   localparam logic [DATA_W-1:0] CANCEL_MASK = DATA_W'(1) << CTRL_CANCEL_BIT;

   for (genvar k = 0; k < NODE_WORDS; k++) begin : g_word
      if (k == W_CTRL) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[k] <= '0;
            else if (commit)
               words[k] <= node_d[k];
            else if (sw_we && sw_idx == 3'(k))
               words[k] <= sw_wdata & ~CANCEL_MASK;
            else if (list_clr)
               words[k][CTRL_LIST_BIT] <= 1'b0;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[k] <= '0;
            else if (commit)
               words[k] <= node_d[k];
            else if (sw_we && sw_idx == 3'(k))
               words[k] <= sw_wdata;
         end
      end
   end
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import dcw_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int MEM_AW  = 32,
   parameter int REG_AW  = 12,
   parameter int SIZE_W  = 24,
   parameter int CHAN_ID = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              beat_ok,
   output logic              busy,
   output logic              evt
);
   localparam int SEL_W = REG_AW - WIN_LSB;

   if (REG_AW <= WIN_LSB) begin : g_bad_regaw
      $error("REG_AW must exceed the window offset width");
   end
   if (SIZE_W < 1 || SIZE_W > DATA_W) begin : g_bad_size
      $error("SIZE_W must lie in 1..DATA_W");
   end
   if (DATA_W <= CTRL_CANCEL_BIT || MEM_AW > DATA_W) begin : g_bad_data
      $error("DATA_W too narrow for control or link words");
   end
   if (CHAN_ID < 0 || CHAN_ID >= (1 << SEL_W)) begin : g_bad_chan
      $error("CHAN_ID does not fit the window select field");
   end

   walk_state_e st;
   logic        first;

   logic [5:0]  off;
   logic        win_hit, word_sel, wr_word, ctrl_wr;
   logic [2:0]  word_idx;
   logic        cancel_wr, start_go, sw_we;
   logic        in_copy, in_fetch;

   logic [NODE_WORDS-1:0][DATA_W-1:0] node_q;
   logic [NODE_WORDS-1:0][DATA_W-1:0] words;
   logic        node_ready, abort_done, commit;
   logic        fetch_start, fetch_cancel;
   logic [MEM_AW-1:0] link;
   logic        link_zero;
   logic [SIZE_W-1:0] remain;
   logic        cnt_counting, cnt_done, cnt_clear;
   logic        list_clr;

   assign off      = reg_addr[WIN_LSB-1:0];
   assign win_hit  = (reg_addr[REG_AW-1:WIN_LSB] == SEL_W'(CHAN_ID));
   assign word_sel = win_hit && !off[5] && (off[1:0] == 2'b00);
   assign word_idx = off[4:2];
   assign wr_word  = reg_wr && word_sel;
   assign ctrl_wr  = wr_word && (word_idx == 3'(W_CTRL));

   assign in_copy   = (st == WALK_COPY);
   assign in_fetch  = (st == WALK_FETCH);
   assign busy      = (st != WALK_IDLE);
   assign cancel_wr = ctrl_wr && reg_wdata[CTRL_CANCEL_BIT] && busy;
   assign start_go  = ctrl_wr && !busy && reg_wdata[CTRL_LIST_BIT]
                      && !reg_wdata[CTRL_CANCEL_BIT];
   assign sw_we     = wr_word && !busy;

   assign link      = words[W_LINK][MEM_AW-1:0];
   assign link_zero = (link == '0);

   assign commit       = in_fetch && node_ready && !cancel_wr;
   assign fetch_cancel = in_fetch && cancel_wr;
   assign fetch_start  = start_go || (in_copy && cnt_done && !cancel_wr && !link_zero);
   assign cnt_clear    = in_copy && cancel_wr;
   assign list_clr     = (in_copy && (cancel_wr || (cnt_done && link_zero)))
                       || (in_fetch && (abort_done || (node_ready && cancel_wr)));

   dcw_fetch #(
      .DATA_W     (DATA_W),
      .MEM_AW     (MEM_AW),
      .NODE_WORDS (NODE_WORDS)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fetch_start),
      .start_addr (link),
      .cancel     (fetch_cancel),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .node_q     (node_q),
      .node_ready (node_ready),
      .abort_done (abort_done)
   );

   dcw_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .node_d   (node_q),
      .sw_we    (sw_we),
      .sw_idx   (word_idx),
      .sw_wdata (reg_wdata),
      .list_clr (list_clr),
      .words    (words)
   );

   dcw_bytecount #(
      .SIZE_W (SIZE_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (commit),
      .load_val (node_q[W_SIZE][SIZE_W-1:0]),
      .beat     (beat_ok && in_copy),
      .clear    (cnt_clear),
      .remain   (remain),
      .counting (cnt_counting),
      .done     (cnt_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WALK_IDLE;
         first <= 1'b0;
         evt   <= 1'b0;
      end else begin
         evt <= 1'b0;
         unique case (st)
            WALK_IDLE: begin
               if (start_go) begin
                  st    <= WALK_FETCH;
                  first <= 1'b1;
               end
            end
            WALK_FETCH: begin
               if (abort_done) begin
                  st <= WALK_IDLE;
               end else if (node_ready) begin
                  if (cancel_wr) begin
                     st <= WALK_IDLE;
                  end else begin
                     st    <= WALK_COPY;
                     evt   <= first;
                     first <= 1'b0;
                  end
               end
            end
            WALK_COPY: begin
               if (cancel_wr) begin
                  st <= WALK_IDLE;
               end else if (cnt_done) begin
                  evt <= 1'b1;
                  st  <= link_zero ? WALK_IDLE : WALK_FETCH;
               end
            end
            default: st <= WALK_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (word_sel)
         reg_rdata = words[word_idx];
      else if (win_hit && off == OFF_REMAIN)
         reg_rdata = DATA_W'(remain);
   end

   logic unused_ok;
   assign unused_ok = cnt_counting;
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
   parameter int MEM_AW = 32,
   parameter int SIZE_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              busy,
   input logic              evt,
   input logic              in_copy,
   input logic              cancel_wr,
   input logic [SIZE_W-1:0] remain
);
   // R2: node reads are always word aligned
   p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   // R2: a request is held with a steady address until data returns
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R2: no memory traffic while idle
   p_no_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R4: the count reads all ones whenever the walker is idle
   p_remain_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> remain == '1);

   // R5: event pulses are never back to back
   p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

   // R8: cancel during a copy stops the walker at once
   p_cancel_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_copy && cancel_wr) |=> !busy);
endmodule

bind dma_chain_walker dcw_checker #(
   .MEM_AW (MEM_AW),
   .SIZE_W (SIZE_W)
) u_dcw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .busy       (busy),
   .evt        (evt),
   .in_copy    (in_copy),
   .cancel_wr  (cancel_wr),
   .remain     (remain)
);

// File: tb/test_dma_chain_walker.sv
module test_dma_chain_walker;
   localparam int CLK_PERIOD = 10;
   localparam int CHAN       = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        beat_ok = 1'b0;
   logic        busy;
   logic        evt;

   logic [31:0] mem [64];
   int          mem_gap = 0;
   bit          toggle_beats = 1'b0;
   int          checks = 0;
   int          errors = 0;
   int          evt_cnt = 0;
   int          misalign = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:2]];

   dma_chain_walker #(.CHAN_ID(CHAN)) i_dma_chain_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .beat_ok    (beat_ok),
      .busy       (busy),
      .evt        (evt)
   );

   // memory model: answers a request after mem_gap idle cycles
   initial begin
      int gap;
      gap = 0;
      mem_rvalid = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            if (gap >= mem_gap) begin
               mem_rvalid = 1'b1;
               gap = 0;
            end else begin
               mem_rvalid = 1'b0;
               gap++;
            end
         end else begin
            mem_rvalid = 1'b0;
            gap = 0;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (toggle_beats) beat_ok = ~beat_ok;
   end

   initial forever begin
      @(negedge clk);
      #2;
      if (evt) evt_cnt++;
      if (mem_req && mem_addr[1:0] != 2'b00) misalign++;
   end

   function automatic logic [11:0] ra(input int win, input logic [5:0] off);
      return {6'(win), off};
   endfunction

   function automatic logic [31:0] nw(input logic [31:0] base, input int i);
      return {8'(8'hA0 + i), 16'h0000, base[7:0]};
   endfunction

   task automatic make_node(input logic [31:0] base, input logic [31:0] size,
                            input logic [31:0] link);
      for (int i = 0; i < 8; i++) mem[base[7:2] + 6'(i)] = nw(base, i);
      mem[base[7:2] + 6'd4] = size;
      mem[base[7:2] + 6'd5] = link;
      mem[base[7:2] + 6'd6] = 32'h0;
      mem[base[7:2] + 6'd7] = 32'h0000_0011;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      #2;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk); #2;
         if (!busy) break;
      end
   endtask

   task automatic wait_loaded(input int limit);
      logic [31:0] v;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk); #2;
         reg_read(ra(CHAN, 6'h30), v);
         if (busy && v != 32'h00FF_FFFF) break;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 busy", {31'b0, busy}, 32'd0);
      check("R1 mem_req", {31'b0, mem_req}, 32'd0);
      check("R1 evt", {31'b0, evt}, 32'd0);
      reg_read(ra(CHAN, 6'h30), v); check("R1 count", v, 32'h00FF_FFFF);
      reg_read(ra(CHAN, 6'h1C), v); check("R1 ctrl", v, 32'h0);
   endtask

   task automatic t_single;
      logic [31:0] v;
      int e0;
      beat_ok = 1'b0;
      make_node(32'h20, 32'd3, 32'h0);
      e0 = evt_cnt;
      reg_write(ra(CHAN, 6'h14), 32'h20);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      wait_loaded(60);
      reg_read(ra(CHAN, 6'h30), v); check("R4 count loaded", v, 32'd3);
      @(negedge clk); beat_ok = 1'b1;
      @(negedge clk); beat_ok = 1'b0; #2;
      reg_read(ra(CHAN, 6'h30), v); check("R4 count after beat", v, 32'd2);
      beat_ok = 1'b1;
      wait_idle(40);
      beat_ok = 1'b0;
      repeat (2) @(negedge clk); #2;
      check("R5 single node events", 32'(evt_cnt - e0), 32'd2);
      reg_read(ra(CHAN, 6'h08), v); check("R3 word2", v, nw(32'h20, 2));
      reg_read(ra(CHAN, 6'h10), v); check("R3 size word", v, 32'd3);
      reg_read(ra(CHAN, 6'h1C), v); check("R6 list bit cleared", v & 32'h10, 32'h0);
      check("R6 idle", {31'b0, busy}, 32'd0);
      reg_read(ra(CHAN, 6'h30), v); check("R4 count done", v, 32'h00FF_FFFF);
   endtask

   task automatic t_chain;
      logic [31:0] v;
      int e0;
      make_node(32'h40, 32'd5, 32'h60);
      make_node(32'h60, 32'd0, 32'h80);
      make_node(32'h80, 32'd2, 32'h0);
      mem_gap = 2;
      toggle_beats = 1'b1;
      e0 = evt_cnt;
      reg_write(ra(CHAN, 6'h14), 32'h40);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      wait_idle(400);
      toggle_beats = 1'b0; beat_ok = 1'b0; mem_gap = 0;
      repeat (2) @(negedge clk); #2;
      check("R7 chain idle", {31'b0, busy}, 32'd0);
      check("R5 three node events", 32'(evt_cnt - e0), 32'd4);
      reg_read(ra(CHAN, 6'h08), v); check("R7 last node word2", v, nw(32'h80, 2));
      reg_read(ra(CHAN, 6'h14), v); check("R6 last link", v, 32'h0);
   endtask

   task automatic t_unaligned;
      logic [31:0] v;
      make_node(32'h20, 32'd1, 32'h0);
      beat_ok = 1'b1;
      reg_write(ra(CHAN, 6'h14), 32'h22);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      wait_idle(60);
      beat_ok = 1'b0;
      check("R2 aligned reads", 32'(misalign), 32'd0);
      reg_read(ra(CHAN, 6'h0C), v); check("R2 node from aligned base", v, nw(32'h20, 3));
   endtask

   task automatic t_cyclic;
      logic [31:0] v;
      int e0;
      make_node(32'hA0, 32'd1, 32'hC0);
      make_node(32'hC0, 32'd2, 32'hA0);
      beat_ok = 1'b1;
      e0 = evt_cnt;
      reg_write(ra(CHAN, 6'h14), 32'hA0);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      repeat (300) @(negedge clk); #2;
      check("R7 cyclic still running", {31'b0, busy}, 32'd1);
      check("R7 cyclic many events", {31'b0, (evt_cnt - e0) >= 10}, 32'd1);
      reg_write(ra(CHAN, 6'h1C), 32'h0010_0000);
      wait_idle(30);
      beat_ok = 1'b0;
      check("R8 cyclic cancelled", {31'b0, busy}, 32'd0);
      reg_read(ra(CHAN, 6'h30), v); check("R8 count after cancel", v, 32'h00FF_FFFF);
   endtask

   task automatic t_cancel_copy;
      logic [31:0] v;
      int e0;
      make_node(32'h20, 32'hFF, 32'h0);
      beat_ok = 1'b0;
      reg_write(ra(CHAN, 6'h14), 32'h20);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      wait_loaded(60);
      reg_write(ra(CHAN, 6'h14), 32'h1234);
      e0 = evt_cnt;
      reg_write(ra(CHAN, 6'h1C), 32'h0010_0000);
      check("R8 stop at cancel", {31'b0, busy}, 32'd0);
      reg_read(ra(CHAN, 6'h30), v); check("R8 count cleared", v, 32'h00FF_FFFF);
      beat_ok = 1'b1;
      repeat (5) @(negedge clk); #2;
      beat_ok = 1'b0;
      check("R8 no completion event", 32'(evt_cnt - e0), 32'd0);
      reg_read(ra(CHAN, 6'h14), v); check("R11 busy write ignored", v, 32'h0);
   endtask

   task automatic t_cancel_fetch;
      logic [31:0] v;
      int e0;
      bit seen;
      make_node(32'hE0, 32'd4, 32'h0);
      mem_gap = 8;
      e0 = evt_cnt;
      reg_write(ra(CHAN, 6'h14), 32'hE0);
      reg_write(ra(CHAN, 6'h1C), 32'h11);
      repeat (3) @(negedge clk);
      reg_write(ra(CHAN, 6'h1C), 32'h0010_0000);
      seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (mem_rvalid) begin seen = 1'b1; break; end
         @(negedge clk); #2;
      end
      check("R9 outstanding read completes", {31'b0, seen}, 32'd1);
      @(negedge clk); #2;
      check("R9 idle after read", {31'b0, busy}, 32'd0);
      mem_gap = 0;
      reg_read(ra(CHAN, 6'h08), v); check("R9 partial node dropped", v, nw(32'h20, 2));
      check("R9 no event", 32'(evt_cnt - e0), 32'd0);
   endtask

   task automatic t_window;
      logic [31:0] v;
      reg_write(ra(CHAN + 1, 6'h14), 32'h55);
      reg_read(ra(CHAN, 6'h14), v); check("R10 foreign write ignored", v, 32'hE0);
      reg_read(ra(CHAN + 1, 6'h14), v); check("R10 foreign read zero", v, 32'h0);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      #2;
      t_reset();
      rst_n = 1'b1;
      t_single();
      t_chain();
      t_unaligned();
      t_cyclic();
      t_cancel_copy();
      t_cancel_fetch();
      t_window();
      finish_run();
   end
endmodule